// File: doc/BRIEF.md
# Divided Data Clock Input Capture

This block lives wholly in the fast converter clock domain. It divides that clock by 1, 2, 4 or 8, according to a mode input, and drives the result out as a data clock for an upstream source. Once per data-clock period it latches a parallel data word on one chosen fast-clock rising edge. It then presents the word, held, together with a one-cycle valid strobe to a downstream interpolation stage.

A polarity input picks the capture edge. With polarity 0 it is the fast-clock edge just before the generated data clock falls. With polarity 1 it is the edge just before the data clock rises. The same rule holds in every divided ratio. Any change of mode or polarity restarts the divider and holds off captures for one full period. In divide-by-1 the divider is bypassed and every edge captures.

Top module: `dclk_capture`

## Requirements
- R1: `mode_i` selects the ratio N as 2 to the power of its value: 2'b00 gives N=1, 2'b01 gives N=2, 2'b10 gives N=4 and 2'b11 gives N=8. In the divided modes `dclk_o` repeats with a period of N fast-clock cycles.
- R2: The restart edge is the first fast-clock edge with a new mode or polarity. Counting it as edge 0, `dclk_o` is high after edges k where (k mod N) < N/2 and low after the rest.
- R3: With `pol_i`=0 in a divided mode, capture edges are the edges k with k >= N+1 and (k-1) mod N = N/2-1. This is the edge after which `dclk_o` falls.
- R4: With `pol_i`=1 in a divided mode, capture edges are the edges k with k >= N+1 and (k-1) mod N = N-1. This is the edge after which `dclk_o` rises.
- R5: In a divided mode `valid_o` is high for exactly one cycle after each capture edge, and `data_o` then equals `data_i` as sampled on that edge.
- R6: A change of mode or polarity cancels any capture pending on the restart edge. `dclk_o` is high after that edge and `valid_o` is low.
- R7: `data_o` keeps its value in every cycle in which `valid_o` is low.
- R8: With `mode_i`=2'b00, `dclk_o` and `valid_o` are high after every edge, and `data_o` is `data_i` from the previous edge.
- R9: While `rst_ni` is low, `dclk_o` and `valid_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ratio select, N = 2**mode_i |
| pol_i | input | 1 | Capture edge select: 0 = before fall, 1 = before rise |
| data_i | input | 16 | Parallel input word |
| dclk_o | output | 1 | Generated data clock |
| data_o | output | 16 | Held captured word |
| valid_o | output | 1 | One-cycle capture strobe |

## Verification
Every output comes from a register, so each result is due exactly one fast-clock edge after the edge that caused it. The bench numbers the edges from the restart edge and derives the expected `dclk_o`, `valid_o` and `data_o` for edge k from the formulas in R2 to R5. It drives inputs on the falling edge and samples the outputs on the next falling edge, half a period after the edge it checks. The mid-period polarity flip is checked the same way, on the edge where the cancelled capture would otherwise have landed.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int DEF_DATA_W = 16;
  localparam int DEF_MODE_W = 2;

  // Counter width able to hold the largest ratio minus one.
  function automatic int cnt_width(int mode_w);
    int max_last;
    max_last = (1 << ((1 << mode_w) - 1)) - 1;
    return (max_last < 2) ? 1 : $clog2(max_last + 1);
  endfunction

endpackage

// File: rtl/dcc_ratio_ctr.sv
module dcc_ratio_ctr #(
  parameter int MODE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic [CNT_W-1:0]  last_o,
  output logic              armed_o,
  output logic              restart_o
);

  logic [MODE_W:0]    cfg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               armed_q;
  logic               wrap;

  always_comb begin
    last_o    = CNT_W'((32'd1 << mode_i) - 32'd1);
    restart_o = ({mode_i, pol_i} != cfg_q);
    wrap      = (cnt_q == last_o);
    if (restart_o || wrap) cnt_nxt_o = '0;
    else                   cnt_nxt_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cfg_q <= {mode_i, pol_i};
      cnt_q <= cnt_nxt_o;
      // arm only after one full period under the current settings
      if (restart_o)  armed_q <= 1'b0;
      else if (wrap)  armed_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/dcc_phase_sel.sv
module dcc_phase_sel #(
  parameter int MODE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic [CNT_W-1:0]  last_i,
  input  logic              armed_i,
  input  logic              restart_i,
  output logic              dclk_nxt_o,
  output logic              cap_o
);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] sel_pt;
  logic             bypass;

  always_comb begin
    bypass     = (mode_i == '0);
    half       = CNT_W'((32'd1 << mode_i) >> 1);
    dclk_nxt_o = bypass || (cnt_nxt_i < half);
    // pol 0: edge before fall (end of high half); pol 1: edge before rise
    sel_pt     = pol_i ? last_i : (half - CNT_W'(1));
    cap_o      = bypass || (!restart_i && armed_i && (cnt_i == sel_pt));
  end

endmodule

// File: rtl/dcc_capture_reg.sv
module dcc_capture_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              dclk_nxt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_o  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      dclk_o  <= dclk_nxt_i;
      valid_o <= cap_i;
      if (cap_i) data_o <= data_i;
    end
  end

endmodule

// File: rtl/dclk_capture.sv
module dclk_capture
  import dcc_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int MODE_W = DEF_MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int CNT_W = cnt_width(MODE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] last;
  logic             armed;
  logic             restart;
  logic             dclk_nxt;
  logic             cap;

  dcc_ratio_ctr #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .pol_i     (pol_i),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .last_o    (last),
    .armed_o   (armed),
    .restart_o (restart)
  );

  dcc_phase_sel #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_sel (
    .mode_i     (mode_i),
    .pol_i      (pol_i),
    .cnt_i      (cnt),
    .cnt_nxt_i  (cnt_nxt),
    .last_i     (last),
    .armed_i    (armed),
    .restart_i  (restart),
    .dclk_nxt_o (dclk_nxt),
    .cap_o      (cap)
  );

  dcc_capture_reg #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .dclk_nxt_i (dclk_nxt),
    .data_i     (data_i),
    .dclk_o     (dclk_o),
    .data_o     (data_o),
    .valid_o    (valid_o)
  );

endmodule

// File: rtl/dclk_capture_chk.sv
module dclk_capture_chk #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              pol_i,
  input logic [DATA_W-1:0] data_i,
  input logic              dclk_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);

  // R9
  a_r9_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!dclk_o && !valid_o && data_o == '0));

  // R5
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_i != '0) |=> !valid_o);

  // R3 and R4: strobe lands right after the selected data-clock transition
  a_r3_capture_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) != '0) |-> (dclk_o == $past(pol_i)));

  // R6
  a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i != $past(mode_i) || pol_i != $past(pol_i)) && mode_i != '0)
      |=> (!valid_o && dclk_o));

  // R7
  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

  // R8
  a_r8_bypass_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == '0) |=> (dclk_o && valid_o));

  a_r8_bypass_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == '0) |=> (data_o == $past(data_i)));

endmodule

bind dclk_capture dclk_capture_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .pol_i   (pol_i),
  .data_i  (data_i),
  .dclk_o  (dclk_o),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/dclk_capture_test.sv
module dclk_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCASE      = 9;
  // {mode, pol}; neighbours always differ
  localparam logic [2:0] CASES [NCASE] = '{
    3'b01_0, 3'b01_1, 3'b10_0, 3'b11_1, 3'b10_1,
    3'b11_0, 3'b00_0, 3'b01_0, 3'b00_1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic        pol_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        dclk_o;
  logic [15:0] data_o;
  logic        valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] exp_data = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dclk_capture uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .pol_i   (pol_i),
    .data_i  (data_i),
    .dclk_o  (dclk_o),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  function automatic logic [15:0] pat(int c, int k);
    return 16'((c * 16'h1357) ^ (k * 16'h0101) ^ 16'h0A50);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk_i);
    check(dclk_o == 1'b0, "R9 dclk", 32'(dclk_o), 0);
    check(valid_o == 1'b0, "R9 valid", 32'(valid_o), 0);
    check(data_o == '0, "R9 data", 32'(data_o), 0);

    // table walk: restart edge is k=0 for each case
    for (int c = 0; c < NCASE; c++) begin
      int n;
      int sel;
      bit byp;
      mode_i = CASES[c][2:1];
      pol_i  = CASES[c][0];
      data_i = pat(c, 0);
      if (c == 0) rst_ni = 1'b1;
      n   = 1 << CASES[c][2:1];
      byp = (n == 1);
      sel = CASES[c][0] ? n - 1 : n / 2 - 1;
      for (int k = 0; k <= 3 * n + 1; k++) begin
        bit cap;
        bit edk;
        @(posedge clk_i);
        @(negedge clk_i);
        if (byp) begin
          cap = 1'b1;
          edk = 1'b1;
        end else begin
          cap = (k >= n + 1) && (((k - 1) % n) == sel);
          edk = (k % n) < (n / 2);
        end
        if (cap) exp_data = pat(c, k);
        if (byp) begin
          check(dclk_o == 1'b1, "R8 dclk high", 32'(dclk_o), 1);
          check(valid_o == 1'b1, "R8 valid high", 32'(valid_o), 1);
          check(data_o == exp_data, "R8 data", 32'(data_o), 32'(exp_data));
        end else begin
          check(dclk_o == edk, "R1 R2 dclk waveform", 32'(dclk_o), 32'(edk));
          check(valid_o == cap, CASES[c][0] ? "R4 R5 valid" : "R3 R5 valid",
                32'(valid_o), 32'(cap));
          check(data_o == exp_data, cap ? "R5 data" : "R7 hold",
                32'(data_o), 32'(exp_data));
          if (k == 0)
            check(!valid_o && dclk_o, "R6 restart edge", {valid_o, dclk_o}, 32'b01);
        end
        data_i = pat(c, k + 1);
      end
    end

    // mid-period polarity flip cancels the pending pol-0 capture (R6)
    mode_i = 2'b10;
    pol_i  = 1'b0;
    data_i = 16'hC0DE;
    for (int k = 0; k <= 5; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      check(valid_o == 1'b0, "R6 no early capture", 32'(valid_o), 0);
    end
    exp_data = data_o;
    pol_i = 1'b1;
    data_i = 16'hBEEF;
    @(posedge clk_i);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R6 flip suppresses capture", 32'(valid_o), 0);
    check(dclk_o == 1'b1, "R6 flip restarts high", 32'(dclk_o), 1);
    check(data_o == exp_data, "R7 flip keeps data", 32'(data_o), 32'(exp_data));

    // asynchronous reset mid-run (R9)
    mode_i = 2'b00;
    repeat (2) @(negedge clk_i);
    check(valid_o == 1'b1, "R8 before reset", 32'(valid_o), 1);
    rst_ni = 1'b0;
    #1;
    check(dclk_o == 1'b0, "R9 async dclk", 32'(dclk_o), 0);
    check(valid_o == 1'b0, "R9 async valid", 32'(valid_o), 0);
    check(data_o == '0, "R9 async data", 32'(data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end

endmodule